// File: doc/BRIEF.md
# Segment descriptor check unit

This block holds one loaded segment descriptor and checks every memory access made through it. Software or a table walker loads the eight-byte descriptor as two 32-bit words. From those words the block decodes the base, the limit, the granularity, the privilege level, the present flag, the segment kind and the accessed flag.

Each access request carries an offset, an access size, an access kind and the requester's privilege. One cycle later the block returns either the 32-bit linear address or a fault with its vector number. On every successful access it sets the accessed flag it holds. It also presents the updated upper descriptor word on a write-back strobe, so the copy in memory can be refreshed.

Top module: `seg_desc_check`

## Requirements
- R1: Word layout. With `ld_sel`=0 the loaded word is the low word: limit bits 15:0 sit in bits 15:0 and base bits 15:0 in bits 31:16. With `ld_sel`=1 it is the high word. Its fields are:
  - base 23:16 in bits 7:0;
  - the accessed flag in bit 8;
  - the read/write permission in bit 9;
  - bit 10, which is ignored;
  - the code flag in bit 11;
  - S in bit 12;
  - DPL in bits 14:13;
  - present in bit 15;
  - limit 19:16 in bits 19:16;
  - granularity G in bit 23;
  - base 31:24 in bits 31:24.
- R2: The response to a request comes exactly one cycle later (`rsp_valid`). When there is no fault, `rsp_lin` = base + offset modulo 2^32 and `rsp_vector` = 0. On a fault, `rsp_lin` = 0.
- R3: Reset clears the descriptor. A descriptor whose present bit is 0 faults every access with vector 11.
- R4: A present descriptor with S=0 (a system segment) faults every access with vector 13.
- R5: With the effective privilege max(CPL, RPL) greater than DPL, any access kind faults with vector 13.
- R6: Access kinds are encoded on `req_kind` as 0 = read, 1 = write, 2 = fetch and 3 = reserved. The following fault with vector 13:
  - a write to a code segment;
  - a write to a data segment with bit 9 = 0;
  - a read of a code segment with bit 9 = 0;
  - a fetch from a data segment;
  - kind 3.
- R7: `req_size` encodes the access size minus one (0..3 for 1..4 bytes). With G=0 the access faults with vector 13 when offset + size − 1 > limit. The sum is taken without 32-bit wrap.
- R8: With G=1 the effective limit is {limit, 12'hFFF}. The same end-of-access comparison applies.
- R9: A not-present descriptor yields vector 11 even when the kind, privilege, type or limit check would also fail.
- R10: A successful access sets the stored accessed bit. With the response it pulses `wb_valid` and presents `wb_word`, the high word in use with bit 8 set. A faulting access gives `wb_valid`=0 and leaves the stored bit unchanged.
- R11: A request in the same cycle as a load is judged against the descriptor held before the load. A high-word load in the same cycle as a successful access keeps the loaded value, accessed bit included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe for one descriptor word |
| ld_sel | input | 1 | 0 = low word, 1 = high word |
| ld_data | input | 32 | Descriptor word to load |
| req_valid | input | 1 | Access request strobe |
| req_offset | input | 32 | Offset within the segment |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_size | input | 2 | Access size minus one |
| req_cpl | input | 2 | Current privilege level |
| req_rpl | input | 2 | Requested privilege level of the selector |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_fault | output | 1 | Access faulted |
| rsp_vector | output | 8 | Fault vector (11 or 13), 0 when no fault |
| rsp_lin | output | 32 | Linear address, 0 on fault |
| wb_valid | output | 1 | Accessed-bit write-back strobe |
| wb_word | output | 32 | High descriptor word with accessed bit set |

## Verification
Two functions can fall in the same cycle: a descriptor load and an access that uses the descriptor, along with the accessed-bit update that access makes. The bench provokes this by driving a low-word load and a request together, then a high-word load and a successful request together. The first response must carry the old base. The write-back word must be the old high word with bit 8 set. The next access must show the newly loaded base, and a write-back word built from the loaded high word rather than a merge of the two.

// File: rtl/seg_desc_check.sv
module seg_desc_check #(
  parameter logic [7:0] VEC_NP = 8'd11,
  parameter logic [7:0] VEC_GP = 8'd13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic        ld_sel,
  input  logic [31:0] ld_data,
  input  logic        req_valid,
  input  logic [31:0] req_offset,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_cpl,
  input  logic [1:0]  req_rpl,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [7:0]  rsp_vector,
  output logic [31:0] rsp_lin,
  output logic        wb_valid,
  output logic [31:0] wb_word
);

  localparam int ABIT = 8;

  logic [31:0] lo_q, hi_q;

  logic [31:0] seg_base, eff_lim;
  logic [19:0] raw_lim;
  logic [32:0] last_byte;
  logic [1:0]  eprl;
  logic        present, is_sys, is_code, rw_ok;
  logic        bad_priv, bad_type, bad_lim, bad_any, ok;
  logic [7:0]  vec;

  assign seg_base  = {hi_q[31:24], hi_q[7:0], lo_q[31:16]};
  assign raw_lim   = {hi_q[19:16], lo_q[15:0]};
  assign eff_lim   = hi_q[23] ? {raw_lim, 12'hFFF} : {12'd0, raw_lim};
  assign present   = hi_q[15];
  assign is_sys    = !hi_q[12];
  assign is_code   = hi_q[11];
  assign rw_ok     = hi_q[9];

  assign eprl      = (req_cpl > req_rpl) ? req_cpl : req_rpl;
  assign last_byte = {1'b0, req_offset} + {31'd0, req_size};

  assign bad_priv  = eprl > hi_q[14:13];
  assign bad_lim   = last_byte > {1'b0, eff_lim};

  always_comb begin
    unique case (req_kind)
      2'd0:    bad_type = is_code && !rw_ok;
      2'd1:    bad_type = is_code || !rw_ok;
      2'd2:    bad_type = !is_code;
      default: bad_type = 1'b1;
    endcase
  end

  assign bad_any = !present || is_sys || bad_priv || bad_type || bad_lim;
  assign ok      = !bad_any;
  assign vec     = !present ? VEC_NP : (bad_any ? VEC_GP : 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q       <= '0;
      hi_q       <= '0;
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_vector <= '0;
      rsp_lin    <= '0;
      wb_valid   <= 1'b0;
      wb_word    <= '0;
    end else begin
      rsp_valid <= req_valid;
      wb_valid  <= req_valid && ok;
      if (req_valid) begin
        rsp_fault  <= bad_any;
        rsp_vector <= vec;
        rsp_lin    <= ok ? seg_base + req_offset : 32'd0;
        wb_word    <= ok ? (hi_q | (32'd1 << ABIT)) : 32'd0;
      end
      if (ld_valid && !ld_sel) lo_q <= ld_data;
      if (ld_valid && ld_sel) hi_q <= ld_data;
      else if (req_valid && ok) hi_q[ABIT] <= 1'b1;
    end
  end

endmodule

module seg_desc_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        ld_valid,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [7:0]  rsp_vector,
  input logic [31:0] rsp_lin,
  input logic        wb_valid,
  input logic [31:0] wb_word,
  input logic [31:0] hi_q
);

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_clean_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_vector == 8'd0));

  p_fault_lin_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_lin == 32'd0));

  p_not_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hi_q[15]) |=> (rsp_fault && rsp_vector == 8'd11));

  p_system_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hi_q[15] && !hi_q[12]) |=> (rsp_fault && rsp_vector == 8'd13));

  p_wb_only_on_success_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rsp_valid && !rsp_fault && wb_word[8]));

  p_acc_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !$past(ld_valid)) |-> hi_q[8]);

endmodule

bind seg_desc_check seg_desc_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ld_valid(ld_valid),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
  .rsp_lin(rsp_lin), .wb_valid(wb_valid), .wb_word(wb_word), .hi_q(hi_q)
);

// File: tb/seg_desc_check_bench.sv
`timescale 1ns/1ps
module seg_desc_check_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_sel = 1'b0;
  logic [31:0] ld_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_kind = '0, req_size = '0, req_cpl = '0, req_rpl = '0;
  logic        rsp_valid, rsp_fault, wb_valid;
  logic [7:0]  rsp_vector;
  logic [31:0] rsp_lin, wb_word;

  always #2 clk = ~clk;

  seg_desc_check u_seg_desc_check (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data),
    .req_valid(req_valid), .req_offset(req_offset), .req_kind(req_kind),
    .req_size(req_size), .req_cpl(req_cpl), .req_rpl(req_rpl),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
    .rsp_lin(rsp_lin), .wb_valid(wb_valid), .wb_word(wb_word)
  );

  typedef struct {
    logic        fault;
    logic [7:0]  vec;
    logic [31:0] lin;
    logic        wb;
    logic [31:0] wbw;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0;
  logic [31:0] m_lo = '0, m_hi = '0;
  bit          finished = 1'b0;

  function automatic logic [31:0] mk_lo(logic [31:0] b, logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] mk_hi(logic [31:0] b, logic [19:0] l, bit g, bit p,
                                         logic [1:0] dpl, bit s, bit code, bit rw, bit a);
    logic [31:0] w;
    w = '0;
    w[31:24] = b[31:24]; w[7:0] = b[23:16]; w[19:16] = l[19:16];
    w[23] = g; w[15] = p; w[14:13] = dpl; w[12] = s; w[11] = code; w[9] = rw; w[8] = a;
    return w;
  endfunction

  function automatic exp_t predict(logic [31:0] lo, logic [31:0] hi, logic [31:0] off,
                                   logic [1:0] kind, logic [1:0] sz, logic [1:0] cpl,
                                   logic [1:0] rpl, string tag);
    exp_t e;
    logic [31:0] base, lim;
    logic [63:0] endb;
    int pr;
    bit gp;
    base = {hi[31:24], hi[7:0], lo[31:16]};
    lim  = {12'd0, hi[19:16], lo[15:0]};
    if (hi[23]) lim = (lim << 12) | 32'hFFF;
    endb = 64'(off) + 64'(sz);
    pr = (cpl > rpl) ? int'(cpl) : int'(rpl);
    gp = !hi[12] || (pr > int'(hi[14:13])) || (endb > 64'(lim));
    case (kind)
      2'd0: gp |= hi[11] && !hi[9];
      2'd1: gp |= hi[11] || !hi[9];
      2'd2: gp |= !hi[11];
      default: gp = 1'b1;
    endcase
    e.tag = tag;
    if (!hi[15]) begin e.fault = 1; e.vec = 8'd11; end
    else if (gp) begin e.fault = 1; e.vec = 8'd13; end
    else begin e.fault = 0; e.vec = 8'd0; end
    e.lin = e.fault ? 32'd0 : base + off;
    e.wb  = !e.fault;
    e.wbw = hi | 32'h100;
    return e;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic step(bit ldv, bit lds, logic [31:0] ldd, bit rq, logic [31:0] off,
                      logic [1:0] kind, logic [1:0] sz, logic [1:0] cpl, logic [1:0] rpl,
                      string tag);
    exp_t e;
    @(negedge clk);
    ld_valid = ldv; ld_sel = lds; ld_data = ldd;
    req_valid = rq; req_offset = off; req_kind = kind; req_size = sz;
    req_cpl = cpl; req_rpl = rpl;
    if (rq) begin
      e = predict(m_lo, m_hi, off, kind, sz, cpl, rpl, tag);
      sb.push_back(e);
    end
    if (ldv && !lds) m_lo = ldd;
    if (ldv && lds) m_hi = ldd;
    else if (rq && e.wb) m_hi[8] = 1'b1;
  endtask

  task automatic load(logic [31:0] lo, logic [31:0] hi);
    step(1, 0, lo, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, hi, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic acc(logic [31:0] off, logic [1:0] kind, logic [1:0] sz,
                     logic [1:0] cpl, logic [1:0] rpl, string tag);
    step(0, 0, 0, 1, off, kind, sz, cpl, rpl, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 unexpected response: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "fault", 32'(rsp_fault), 32'(e.fault));
        chk(e.tag, "vector", 32'(rsp_vector), 32'(e.vec));
        chk(e.tag, "lin", rsp_lin, e.lin);
        chk(e.tag, "wb_valid", 32'(wb_valid), 32'(e.wb));
        if (e.wb) chk(e.tag, "wb_word", wb_word, e.wbw);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo, hi;
    repeat (3) @(negedge clk);
    chk("R3", "reset rsp_valid", 32'(rsp_valid), 0);
    chk("R3", "reset wb_valid", 32'(wb_valid), 0);
    rst_n = 1'b1;
    acc(32'h10, 0, 3, 0, 0, "R3");

    // Byte-granular writable data, base 0x1000_0000, limit 0xFF, DPL 3
    lo = mk_lo(32'h1000_0000, 20'h000FF);
    hi = mk_hi(32'h1000_0000, 20'h000FF, 0, 1, 2'd3, 1, 0, 1, 0);
    load(lo, hi);
    acc(32'h10, 0, 3, 3, 0, "R2");
    acc(32'h20, 1, 1, 0, 0, "R10");
    acc(32'hFC, 0, 3, 0, 0, "R7");
    acc(32'hFD, 0, 3, 0, 0, "R7");
    acc(32'hFF, 1, 0, 0, 0, "R7");
    acc(32'h100, 0, 0, 0, 0, "R7");
    acc(32'h04, 2, 0, 0, 0, "R6");
    acc(32'h04, 3, 0, 0, 0, "R6");

    // Read-only data, DPL 1, base with all three base bytes distinct
    lo = mk_lo(32'h1234_5678, 20'h00FFF);
    hi = mk_hi(32'h1234_5678, 20'h00FFF, 0, 1, 2'd1, 1, 0, 0, 0);
    load(lo, hi);
    acc(32'h8, 0, 0, 1, 0, "R1");
    acc(32'h8, 1, 0, 0, 0, "R6");
    acc(32'h8, 0, 0, 1, 2, "R5");
    acc(32'h8, 0, 0, 2, 0, "R5");
    acc(32'h8, 0, 0, 0, 1, "R5");

    // Page-granular, limit 1 -> effective 0x1FFF, base wraps
    lo = mk_lo(32'hFFFF_F000, 20'h00001);
    hi = mk_hi(32'hFFFF_F000, 20'h00001, 1, 1, 2'd0, 1, 0, 1, 0);
    load(lo, hi);
    acc(32'h1FFF, 0, 0, 0, 0, "R8");
    acc(32'h1FFE, 1, 1, 0, 0, "R8");
    acc(32'h1FFF, 0, 1, 0, 0, "R8");
    acc(32'h2000, 0, 0, 0, 0, "R8");
    acc(32'h1000, 0, 0, 0, 0, "R2");

    // Full 4 GB page-granular: end-of-access must not wrap
    lo = mk_lo(32'h0, 20'hFFFFF);
    hi = mk_hi(32'h0, 20'hFFFFF, 1, 1, 2'd0, 1, 0, 1, 0);
    load(lo, hi);
    acc(32'hFFFF_FFFC, 0, 3, 0, 0, "R8");
    acc(32'hFFFF_FFFF, 0, 1, 0, 0, "R7");

    // Code segments: readable and execute-only
    lo = mk_lo(32'h0040_0000, 20'h0FFFF);
    hi = mk_hi(32'h0040_0000, 20'h0FFFF, 0, 1, 2'd0, 1, 1, 1, 0);
    load(lo, hi);
    acc(32'h100, 2, 0, 0, 0, "R6");
    acc(32'h100, 0, 3, 0, 0, "R6");
    acc(32'h100, 1, 0, 0, 0, "R6");
    hi = mk_hi(32'h0040_0000, 20'h0FFFF, 0, 1, 2'd0, 1, 1, 0, 0);
    load(lo, hi);
    acc(32'h100, 0, 0, 0, 0, "R6");
    acc(32'h100, 2, 0, 0, 0, "R6");

    // System segment and not-present priority
    hi = mk_hi(32'h0040_0000, 20'h0FFFF, 0, 1, 2'd0, 0, 0, 1, 0);
    load(lo, hi);
    acc(32'h10, 0, 0, 0, 0, "R4");
    hi = mk_hi(32'h0040_0000, 20'h0FFFF, 0, 0, 2'd0, 0, 0, 1, 0);
    load(lo, hi);
    acc(32'h10, 0, 0, 0, 0, "R9");
    hi = mk_hi(32'h0040_0000, 20'h0000F, 0, 0, 2'd0, 1, 1, 0, 0);
    load(lo, hi);
    acc(32'hFFFF, 1, 3, 3, 3, "R9");

    // Accessed flag only on success
    lo = mk_lo(32'h0000_8000, 20'h000FF);
    hi = mk_hi(32'h0000_8000, 20'h000FF, 0, 1, 2'd3, 1, 0, 1, 0);
    load(lo, hi);
    acc(32'h200, 0, 0, 0, 0, "R10");
    acc(32'h10, 0, 0, 0, 0, "R10");
    acc(32'h11, 0, 0, 0, 0, "R10");

    // Collisions: load and request together
    step(1, 0, mk_lo(32'h0000_9000, 20'h000FF), 1, 32'h4, 0, 0, 0, 0, "R11");
    acc(32'h4, 0, 0, 0, 0, "R11");
    hi = mk_hi(32'h7700_9000, 20'h000FF, 0, 1, 2'd3, 1, 0, 1, 0);
    step(1, 1, hi, 1, 32'h8, 1, 0, 0, 0, "R11");
    acc(32'h8, 0, 0, 0, 0, "R11");
    acc(32'h9, 0, 0, 0, 0, "R11");

    @(negedge clk);
    req_valid = 0; ld_valid = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing responses: actual %0d expected 0", sb.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule